// File: doc/BRIEF.md
# Write Leveling Sequence Controller

This block runs the write-leveling calibration step of a DDR memory controller without processor help. It acts as a small master on a request/acknowledge register bus. A one-cycle `start` pulse launches a fixed sequence. The sequence first saves the settings it is about to disturb and quiets the controller: power-down timers, auto refresh and periodic impedance calibration are all switched off. It then places the DRAM in leveling mode with a mode-register command and kicks the controller's hardware leveling engine. It polls that engine until it reports completion and gathers the error flags of one or two PHYs. Finally it takes the DRAM out of leveling mode and puts every saved setting back.

The result appears as a one-cycle `done` pulse and an `error` flag. The flag stays valid until the next start. A programmable poll budget bounds the wait on the engine. When the budget runs out, the sequence jumps straight to the exit and restore steps and reports an error. The controller is therefore never left with refresh disabled.

Top module: `wlvl_seq_ctrl`

## Requirements
- R1: After reset, `bus_req`, `busy`, `done` and `error` are all 0.
- R2: Each register access raises `bus_req` and holds `bus_we`, `bus_addr` and `bus_wdata` steady until `bus_ack` is seen. Exactly one access is made per request. Register byte offsets are: power-down control 0x004, auto-power-saving 0x008, refresh control 0x00C, impedance-calibration control 0x010, special-command 0x014, leveling control 0x018. The second PHY's leveling control sits 0x100 above the first PHY's.
- R3: Before leveling, the block performs four writes in this order. Power-down control is written with its read value with bits 15:8 cleared. Auto-power-saving is written with its read value with bit 0 set. Refresh control is written with 0x0000C000, after its old value has been read and saved. Impedance-calibration control is written with its saved value with bits 1:0 cleared.
- R4: Next, special-command is written with 0x00808231 (leveling-enable bit 9 set). Then leveling control is written with 1 to start the engine.
- R5: The block then reads leveling control repeatedly while its bit 0 reads 1. It stops at the first read whose bit 0 is 0.
- R6: An error is flagged if bits 11:8 of the first PHY's leveling control are nonzero on that final read. When `dual_phy` is 1, the block also reads the second PHY's leveling control once and flags an error if its bits 11:8 are nonzero. When `dual_phy` is 0, the second PHY is never accessed.
- R7: To leave leveling, special-command is written with `{mr1_init, 16'h8031}`, which has bit 9 clear. Refresh control and impedance-calibration control are then written back with their saved values.
- R8: Last, power-down control is written with its read value OR 0x5500. Auto-power-saving is written with its read value with bit 3 cleared. Special-command is written with 0.
- R9: `busy` is high from the cycle after an accepted start until the last access completes. `done` is high for exactly one cycle at the end. `error` holds its value until the next accepted start clears it.
- R10: If the count of poll reads with bit 0 set reaches `poll_limit` (a limit of 0 acts as 1), polling stops. The second PHY is not read. The R7 and R8 writes are still all made, and `error` is 1.
- R11: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| dual_phy | input | 1 | 1: gather errors from both PHYs |
| mr1_init | input | 16 | Mode-register value restored on leveling exit |
| poll_limit | input | TW (16) | Maximum busy poll reads before abort |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW (16) | Register byte offset |
| bus_wdata | output | DW (32) | Write data |
| bus_ack | input | 1 | Access completed this cycle |
| bus_rdata | input | DW (32) | Read data, valid with `bus_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Leveling or timeout error of the last run |

## Verification
The bench sweeps PHY count, per-PHY error codes, engine busy length, bus acknowledge latency and poll budget. It compares the complete write log and the final register contents against values computed from the requirements.

Several corner cases are targeted directly:
- An engine that finishes on the very first poll. A design that always re-polls would show an extra read.
- A busy length one short of the budget and exactly equal to it. An off-by-one timer would either abort a good run or hang one poll too long.
- Aborted runs. A design that skips the restore steps on abort would leave refresh stopped.
- A second-PHY error while only one PHY is selected. A design that reads the second PHY unconditionally would wrongly report it.
- A start pulse mid-run. This must not restart or duplicate the sequence.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

  localparam int DW_DEF = 32;

  // ordered list of bus operations making up the sequence
  typedef enum logic [4:0] {
    ST_PDC_RD,  ST_PDC_WR,  ST_APS_RD,  ST_APS_WR,
    ST_REF_RD,  ST_REF_WR,  ST_ZQ_RD,   ST_ZQ_WR,
    ST_WL_ENTER, ST_ENG_GO, ST_POLL,    ST_PHY1_RD,
    ST_WL_EXIT, ST_REF_RST, ST_ZQ_RST,
    ST_PDC_RD2, ST_PDC_WR2, ST_APS_RD2, ST_APS_WR2,
    ST_SCMD_CLR
  } step_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_ISSUE, PH_WAIT, PH_DONE
  } phase_e;

  localparam logic [31:0] K_REF_STOP = 32'h0000_C000;
  localparam logic [31:0] K_WL_ENTER = 32'h0080_8231;
  localparam logic [31:0] K_PDC_MASK = 32'h0000_FF00;
  localparam logic [31:0] K_PDC_ON   = 32'h0000_5500;
  localparam logic [31:0] K_ZQ_MASK  = 32'h0000_0003;
  localparam logic [15:0] K_EXIT_LO  = 16'h8031;

  localparam int ENG_BIT     = 0;
  localparam int ERR_LSB     = 8;
  localparam int ERR_W       = 4;
  localparam int APS_OFF_BIT = 0;
  localparam int APS_ON_BIT  = 3;

endpackage

// File: rtl/wlvl_step_decode.sv
module wlvl_step_decode
  import wlvl_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = DW_DEF,
  parameter int A_PWRDN   = 'h004,
  parameter int A_APSV    = 'h008,
  parameter int A_REFR    = 'h00C,
  parameter int A_IMPC    = 'h010,
  parameter int A_SCMD    = 'h014,
  parameter int A_LVLC    = 'h018,
  parameter int PHY_STRIDE = 'h100
) (
  input  step_e           step,
  input  logic [DW-1:0]   hold,
  input  logic [DW-1:0]   sref,
  input  logic [DW-1:0]   szq,
  input  logic [15:0]     mr1,
  output logic            op_we,
  output logic [AW-1:0]   op_addr,
  output logic [DW-1:0]   op_wdata
);

  localparam logic [AW-1:0] AD_PWRDN = AW'(A_PWRDN);
  localparam logic [AW-1:0] AD_APSV  = AW'(A_APSV);
  localparam logic [AW-1:0] AD_REFR  = AW'(A_REFR);
  localparam logic [AW-1:0] AD_IMPC  = AW'(A_IMPC);
  localparam logic [AW-1:0] AD_SCMD  = AW'(A_SCMD);
  localparam logic [AW-1:0] AD_LVL0  = AW'(A_LVLC);
  localparam logic [AW-1:0] AD_LVL1  = AW'(A_LVLC + PHY_STRIDE);

  localparam logic [DW-1:0] APS_OFF = DW'(1) << APS_OFF_BIT;
  localparam logic [DW-1:0] APS_ON  = DW'(1) << APS_ON_BIT;

  always_comb begin
    op_we    = 1'b0;
    op_addr  = AD_SCMD;
    op_wdata = '0;
    unique case (step)
      ST_PDC_RD:   op_addr = AD_PWRDN;
      ST_PDC_WR:   begin op_we = 1'b1; op_addr = AD_PWRDN; op_wdata = hold & ~DW'(K_PDC_MASK); end
      ST_APS_RD:   op_addr = AD_APSV;
      ST_APS_WR:   begin op_we = 1'b1; op_addr = AD_APSV;  op_wdata = hold | APS_OFF; end
      ST_REF_RD:   op_addr = AD_REFR;
      ST_REF_WR:   begin op_we = 1'b1; op_addr = AD_REFR;  op_wdata = DW'(K_REF_STOP); end
      ST_ZQ_RD:    op_addr = AD_IMPC;
      ST_ZQ_WR:    begin op_we = 1'b1; op_addr = AD_IMPC;  op_wdata = szq & ~DW'(K_ZQ_MASK); end
      ST_WL_ENTER: begin op_we = 1'b1; op_addr = AD_SCMD;  op_wdata = DW'(K_WL_ENTER); end
      ST_ENG_GO:   begin op_we = 1'b1; op_addr = AD_LVL0;  op_wdata = DW'(1) << ENG_BIT; end
      ST_POLL:     op_addr = AD_LVL0;
      ST_PHY1_RD:  op_addr = AD_LVL1;
      ST_WL_EXIT:  begin op_we = 1'b1; op_addr = AD_SCMD;  op_wdata = DW'({mr1, K_EXIT_LO}); end
      ST_REF_RST:  begin op_we = 1'b1; op_addr = AD_REFR;  op_wdata = sref; end
      ST_ZQ_RST:   begin op_we = 1'b1; op_addr = AD_IMPC;  op_wdata = szq; end
      ST_PDC_RD2:  op_addr = AD_PWRDN;
      ST_PDC_WR2:  begin op_we = 1'b1; op_addr = AD_PWRDN; op_wdata = hold | DW'(K_PDC_ON); end
      ST_APS_RD2:  op_addr = AD_APSV;
      ST_APS_WR2:  begin op_we = 1'b1; op_addr = AD_APSV;  op_wdata = hold & ~APS_ON; end
      ST_SCMD_CLR: begin op_we = 1'b1; op_addr = AD_SCMD;  op_wdata = '0; end
      default:     op_addr = AD_SCMD;
    endcase
  end

endmodule

// File: rtl/wlvl_bus_master.sv
module wlvl_bus_master #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  logic          req_q, req_d;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          rsp_q;
  logic [DW-1:0] rdat_q;
  logic          load_en, cap_en;

  assign load_en = cmd_valid & ~req_q;
  assign cap_en  = req_q & bus_ack;

  always_comb begin
    req_d = req_q;
    if (load_en)     req_d = 1'b1;
    else if (cap_en) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      rsp_q <= 1'b0;
    end else begin
      req_q <= req_d;
      rsp_q <= cap_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      we_q    <= cmd_we;
      addr_q  <= cmd_addr;
      wdata_q <= cmd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdat_q <= '0;
    else if (cap_en) rdat_q <= bus_rdata;
  end

  assign bus_req   = req_q;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign rsp_valid = rsp_q;
  assign rsp_data  = rdat_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)); // R2
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !bus_req); // R2
  AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_req); // R2

endmodule

// File: rtl/wlvl_poll_timer.sv
module wlvl_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expire
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW:0]   cnt_inc;
  logic          cnt_en;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  // reaching the budget on this busy read ends polling; a zero budget behaves as one
  assign expire  = (cnt_inc >= {1'b0, limit});
  assign cnt_en  = clr | (tick & ~expire);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_inc[TW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wlvl_seq_ctrl.sv
module wlvl_seq_ctrl
  import wlvl_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = DW_DEF,
  parameter int TW         = 16,
  parameter int A_PWRDN    = 'h004,
  parameter int A_APSV     = 'h008,
  parameter int A_REFR     = 'h00C,
  parameter int A_IMPC     = 'h010,
  parameter int A_SCMD     = 'h014,
  parameter int A_LVLC     = 'h018,
  parameter int PHY_STRIDE = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dual_phy,
  input  logic [15:0]   mr1_init,
  input  logic [TW-1:0] poll_limit,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          error
);

  // reset: asserted asynchronously, released on a clock edge
  logic rs_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_n_s <= rs_meta;
    end
  end

  phase_e        ph_q, ph_d;
  step_e         step_q, step_d;
  logic [DW-1:0] hold_q, hold_d;
  logic [DW-1:0] sref_q, sref_d;
  logic [DW-1:0] szq_q, szq_d;
  logic [15:0]   mr1_q, mr1_d;
  logic          dual_q, dual_d;
  logic          eacc_q, eacc_d;
  logic          tmo_q, tmo_d;
  logic          err_q, err_d;

  logic          cmd_valid, op_we;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          tmr_clr, tmr_tick, tmr_expire;
  logic          rsp_err;

  assign rsp_err = |rsp_data[ERR_LSB +: ERR_W];

  wlvl_step_decode #(
    .AW(AW), .DW(DW), .A_PWRDN(A_PWRDN), .A_APSV(A_APSV), .A_REFR(A_REFR),
    .A_IMPC(A_IMPC), .A_SCMD(A_SCMD), .A_LVLC(A_LVLC), .PHY_STRIDE(PHY_STRIDE)
  ) u_dec (
    .step(step_q), .hold(hold_q), .sref(sref_q), .szq(szq_q), .mr1(mr1_q),
    .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata)
  );

  wlvl_bus_master #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n_s),
    .cmd_valid(cmd_valid), .cmd_we(op_we), .cmd_addr(op_addr), .cmd_wdata(op_wdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  wlvl_poll_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .clr(tmr_clr), .tick(tmr_tick),
    .limit(poll_limit), .expire(tmr_expire)
  );

  // next-state logic
  always_comb begin
    ph_d      = ph_q;
    step_d    = step_q;
    hold_d    = hold_q;
    sref_d    = sref_q;
    szq_d     = szq_q;
    mr1_d     = mr1_q;
    dual_d    = dual_q;
    eacc_d    = eacc_q;
    tmo_d     = tmo_q;
    err_d     = err_q;
    cmd_valid = 1'b0;
    tmr_clr   = 1'b0;
    tmr_tick  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d    = PH_ISSUE;
          step_d  = ST_PDC_RD;
          mr1_d   = mr1_init;
          dual_d  = dual_phy;
          eacc_d  = 1'b0;
          tmo_d   = 1'b0;
          err_d   = 1'b0;
          tmr_clr = 1'b1;
        end
      end
      PH_ISSUE: begin
        cmd_valid = 1'b1;
        ph_d      = PH_WAIT;
      end
      PH_WAIT: begin
        if (rsp_valid) begin
          hold_d = rsp_data;
          ph_d   = PH_ISSUE;
          step_d = step_e'(step_q + 5'd1);
          unique case (step_q)
            ST_REF_RD: sref_d = rsp_data;
            ST_ZQ_RD:  szq_d  = rsp_data;
            ST_POLL: begin
              if (rsp_data[ENG_BIT]) begin
                tmr_tick = 1'b1;
                if (tmr_expire) begin
                  tmo_d  = 1'b1;
                  step_d = ST_WL_EXIT;
                end else begin
                  step_d = ST_POLL;
                end
              end else begin
                eacc_d = eacc_q | rsp_err;
                step_d = dual_q ? ST_PHY1_RD : ST_WL_EXIT;
              end
            end
            ST_PHY1_RD: begin
              eacc_d = eacc_q | rsp_err;
              step_d = ST_WL_EXIT;
            end
            ST_SCMD_CLR: begin
              ph_d  = PH_DONE;
              err_d = eacc_q | tmo_q;
            end
            default: ;
          endcase
        end
      end
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ph_q   <= PH_IDLE;
      step_q <= ST_PDC_RD;
      dual_q <= 1'b0;
      mr1_q  <= '0;
      eacc_q <= 1'b0;
      tmo_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      step_q <= step_d;
      dual_q <= dual_d;
      mr1_q  <= mr1_d;
      eacc_q <= eacc_d;
      tmo_q  <= tmo_d;
      err_q  <= err_d;
    end
  end

  // data holding registers, loaded only when a response arrives
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hold_q <= '0;
      sref_q <= '0;
      szq_q  <= '0;
    end else if (rsp_valid) begin
      hold_q <= hold_d;
      sref_q <= sref_d;
      szq_q  <= szq_d;
    end
  end

  assign busy  = (ph_q != PH_IDLE) && (ph_q != PH_DONE);
  assign done  = (ph_q == PH_DONE);
  assign error = err_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done); // R9
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && !start) |=> $stable(error)); // R9
  AST_PHY1_GATED: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_req && (bus_addr == AW'(A_LVLC + PHY_STRIDE)) |-> dual_q && !tmo_q); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> !bus_req); // R11

endmodule

// File: tb/sim_wlvl_seq_ctrl.sv
module sim_wlvl_seq_ctrl;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TW = 16;
  localparam logic [15:0] AD_PDC = 16'h004, AD_APS = 16'h008, AD_REF = 16'h00C,
                          AD_ZQ = 16'h010, AD_SCM = 16'h014, AD_LV0 = 16'h018,
                          AD_LV1 = 16'h118;

  logic clk = 1'b0;
  logic rst_n;
  logic start, dual_phy;
  logic [15:0] mr1_init;
  logic [TW-1:0] poll_limit;
  logic bus_req, bus_we, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic busy, done, error;

  always #4 clk = ~clk;

  wlvl_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dual_phy(dual_phy),
    .mr1_init(mr1_init), .poll_limit(poll_limit),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .error(error)
  );

  int n_run = 0, n_fail = 0;

  // register model and logs
  logic [31:0] m_pdc, m_aps, m_ref, m_zq, m_scm, m_lv;
  logic [3:0]  e0, e1;
  int lat, busy_len, eng_left, n_poll, n_p1, n_wr, wcnt;
  logic [15:0] lg_a [0:31];
  logic [31:0] lg_d [0:31];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // bus slave: acknowledges after lat idle cycles, models the leveling engine
  initial begin
    bus_ack = 1'b0;
    bus_rdata = '0;
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
        wcnt = 0;
      end else if (bus_req) begin
        if (wcnt >= lat) begin
          bus_ack = 1'b1;
          if (bus_we) begin
            if (n_wr < 32) begin lg_a[n_wr] = bus_addr; lg_d[n_wr] = bus_wdata; end
            n_wr++;
            case (bus_addr)
              AD_PDC: m_pdc = bus_wdata;
              AD_APS: m_aps = bus_wdata;
              AD_REF: m_ref = bus_wdata;
              AD_ZQ:  m_zq  = bus_wdata;
              AD_SCM: m_scm = bus_wdata;
              AD_LV0: begin m_lv = bus_wdata; if (bus_wdata[0]) eng_left = busy_len; end
              default: ;
            endcase
          end else begin
            case (bus_addr)
              AD_PDC: bus_rdata = m_pdc;
              AD_APS: bus_rdata = m_aps;
              AD_REF: bus_rdata = m_ref;
              AD_ZQ:  bus_rdata = m_zq;
              AD_SCM: bus_rdata = m_scm;
              AD_LV0: begin
                n_poll++;
                if (eng_left > 0) begin
                  bus_rdata = {20'd0, e0, 8'h01};
                  eng_left--;
                end else bus_rdata = {20'd0, e0, 8'h00};
              end
              AD_LV1: begin n_p1++; bus_rdata = {20'd0, e1, 8'h00}; end
              default: bus_rdata = 32'hDEAD_BEEF;
            endcase
          end
        end else wcnt++;
      end
    end
  end

  function automatic string wtag(input int i);
    if (i < 4) return "R3 prep write";
    if (i < 6) return "R4 enter/start write";
    if (i < 9) return "R7 exit/restore write";
    return "R8 finish write";
  endfunction

  task automatic run_one(input int idx, input bit dual, input logic [3:0] x0,
                         input logic [3:0] x1, input int bl, input int lt, input int lim);
    logic [31:0] pdc0, aps0, ref0, zq0;
    logic [15:0] mr;
    logic [15:0] ea [0:11];
    logic [31:0] ed [0:11];
    bit tmo, exp_err, got, poke;
    int eff_lim, exp_poll;
    pdc0 = 32'hC3A5_F00F ^ (idx * 32'h0101_0107);
    aps0 = 32'h0000_0008 | ((idx & 7) << 4) | (idx & 6);
    ref0 = 32'h0040_1234 + idx;
    zq0  = 32'hA000_0003 ^ (idx << 4);
    mr   = 16'h0004 + 16'(idx);
    m_pdc = pdc0; m_aps = aps0; m_ref = ref0; m_zq = zq0; m_scm = 32'h0; m_lv = 32'h0;
    e0 = x0; e1 = x1; busy_len = bl; lat = lt; eng_left = 0;
    n_poll = 0; n_p1 = 0; n_wr = 0;
    eff_lim = (lim == 0) ? 1 : lim;
    tmo = (bl >= eff_lim);
    exp_poll = tmo ? eff_lim : bl + 1;
    exp_err = tmo ? 1'b1 : ((x0 != 0) || (dual && x1 != 0));
    poke = (idx % 5 == 0);
    ea[0] = AD_PDC; ed[0] = pdc0 & ~32'h0000_FF00;
    ea[1] = AD_APS; ed[1] = aps0 | 32'h1;
    ea[2] = AD_REF; ed[2] = 32'h0000_C000;
    ea[3] = AD_ZQ;  ed[3] = zq0 & ~32'h3;
    ea[4] = AD_SCM; ed[4] = 32'h0080_8231;
    ea[5] = AD_LV0; ed[5] = 32'h1;
    ea[6] = AD_SCM; ed[6] = {mr, 16'h8031};
    ea[7] = AD_REF; ed[7] = ref0;
    ea[8] = AD_ZQ;  ed[8] = zq0;
    ea[9] = AD_PDC; ed[9] = ed[0] | 32'h0000_5500;
    ea[10] = AD_APS; ed[10] = ed[1] & ~32'h8;
    ea[11] = AD_SCM; ed[11] = 32'h0;

    dual_phy = dual; mr1_init = mr; poll_limit = TW'(lim);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    got = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin got = 1'b1; break; end
      if (c == 12) begin
        chk(busy == 1'b1, "R9 busy during run", 32'(busy), 32'h1);
        chk(error == 1'b0, "R9 error cleared by start", 32'(error), 32'h0);
        if (poke) start = 1'b1; // R11: must be ignored
      end
    end
    chk(got, "R9 done reached", 32'(got), 32'h1);
    chk(error == exp_err, "R6/R10 error flag", 32'(error), 32'(exp_err));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 done single cycle", {30'd0, busy, done}, 32'h0);
    repeat (3) @(negedge clk);
    chk(error == exp_err && bus_req == 1'b0, "R9/R11 error held, no extra run",
        {30'd0, bus_req, error}, {31'd0, exp_err});
    chk(n_wr == 12, "R11 write count", 32'(n_wr), 32'd12);
    for (int i = 0; i < 12; i++) begin
      if (i < n_wr)
        chk(lg_a[i] == ea[i] && lg_d[i] == ed[i], wtag(i), lg_d[i], ed[i]);
    end
    chk(n_poll == exp_poll, tmo ? "R10 poll count at timeout" : "R5 poll count",
        32'(n_poll), 32'(exp_poll));
    chk(n_p1 == ((dual && !tmo) ? 1 : 0), "R6 second PHY reads", 32'(n_p1),
        (dual && !tmo) ? 32'd1 : 32'd0);
    chk(m_ref == ref0 && m_zq == zq0, "R7 refresh/impedance restored", m_ref, ref0);
    chk(m_pdc == ed[9] && m_aps == ed[10] && m_scm == 32'h0, "R8 final register state",
        m_pdc, ed[9]);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; dual_phy = 1'b0; mr1_init = '0; poll_limit = '0;
    lat = 0; busy_len = 0; e0 = '0; e1 = '0; eng_left = 0; n_poll = 0; n_p1 = 0; n_wr = 0;
    repeat (3) @(negedge clk);
    chk(bus_req == 0 && busy == 0 && done == 0 && error == 0, "R1 reset state",
        {28'd0, bus_req, busy, done, error}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_req == 0 && busy == 0 && done == 0 && error == 0, "R1 idle after reset",
        {28'd0, bus_req, busy, done, error}, 32'h0);
    begin
      int idx;
      idx = 0;
      for (int d = 0; d < 2; d++)
        for (int a = 0; a < 2; a++)
          for (int b = 0; b < 2; b++)
            for (int bl = 0; bl < 4; bl++)
              for (int lt = 0; lt < 3; lt++)
                for (int li = 0; li < 3; li++) begin
                  run_one(idx, d[0], a[0] ? 4'h5 : 4'h0, b[0] ? 4'h8 : 4'h0, bl, lt,
                          (li == 0) ? 0 : (li == 1) ? 1 : 3);
                  idx++;
                end
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule